// File: doc/BRIEF.md
# Dual-Clock Byte FIFO with Partial Flags

This block is a byte-wide first-in first-out buffer. A producer and a consumer each run on their own clock. The two clocks may be the same net, or they may be entirely unrelated. The producer stores a byte on each write-clock edge where it requests a write. The consumer moves the oldest stored byte into an output register on each read-clock edge where it requests a read.

Four status outputs guide both sides. The read side sees empty, plus an almost-empty warning that covers the last seven entries. The write side sees full, plus an almost-full warning that covers the last seven free slots. Each side computes its own flags from its own pointer and a Gray-coded copy of the other side's pointer. That copy is carried across the clock boundary by a two-stage synchroniser. As a result, a flag can lag the true state by the synchroniser delay, but it never claims data or space that does not exist.

An output enable can float the read data bus. One active-low asynchronous reset empties the buffer. The depth is a power-of-two parameter from 64 to 4096 entries.

Top module: `dcfifo`

## Requirements
- R1: When we_i is high and full_o is low at a rising wclk_i edge, wdata_i[7:0] is stored as the newest entry. The write pointer never advances by more than one entry per edge.
- R2: When re_i is high and empty_o is low at a rising rclk_i edge, the oldest unread byte is loaded into the output register and shows on rdata_o at that edge. Bytes come out in the order they were accepted.
- R3: A write request while full_o is high is ignored. The write pointer and the stored contents stay unchanged, and the dropped byte never appears at the output.
- R4: A read request while empty_o is high is ignored. The read pointer and rdata_o stay unchanged.
- R5: In the read domain, let the level be the synchronised write count minus the read count. empty_o is high when the level is 0, and aempty_o is high when the level is 7 or less. With both clocks on one net, a write accepted at edge k clears empty_o just after edge k+2.
- R6: In the write domain, let the level be the write count minus the synchronised read count. full_o is high when the level equals DEPTH, and afull_o is high when the level is DEPTH-7 or more. With both clocks on one net, a read accepted at edge k frees its slot in full_o just after edge k+2.
- R7: With unrelated clocks, empty_o low implies at least one byte is stored, and full_o low implies at least one slot is free. Every byte is delivered intact and in order. Pointers cross the clock boundary in Gray code, changing at most one bit per edge.
- R8: While rst_ni is low, both pointers are cleared and the output register reads 0x00. In that state empty_o and aempty_o are high, and full_o and afull_o are low.
- R9: When oe_i is low, all eight bits of rdata_o are high impedance. When oe_i is high, rdata_o shows the output register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk_i | input | 1 | Write clock |
| rclk_i | input | 1 | Read clock, may be the same net as wclk_i |
| rst_ni | input | 1 | Active-low asynchronous reset for both domains |
| we_i | input | 1 | Write request |
| wdata_i | input | 8 | Write data |
| re_i | input | 1 | Read request |
| oe_i | input | 1 | Output enable for rdata_o |
| rdata_o | output | 8 | Read data, high impedance when oe_i is low |
| empty_o | output | 1 | No data visible to the read side |
| aempty_o | output | 1 | Seven or fewer entries visible to the read side |
| full_o | output | 1 | No space visible to the write side |
| afull_o | output | 1 | Seven or fewer free slots visible to the write side |

## Verification
The bench builds the block with DEPTH at its smallest value, 64. At that size the full and almost-full edges, and overflow attempts past them, take only a few dozen writes each. In its first phase both clocks run on one net, so the two-edge flag latency is exact, and every flag and every output byte is compared each cycle against a counter-and-queue model. A second phase gives the read side an unrelated 7.4 ns clock. There the bench checks that the flags are never optimistic and that throttled, bursty traffic arrives in order.

// File: rtl/dcfifo_pkg.sv
`timescale 1ns/100ps
package dcfifo_pkg;
  localparam int unsigned DATA_W  = 8;
  localparam int unsigned AE_GAP  = 7;  // almost-empty: level <= AE_GAP
  localparam int unsigned AF_GAP  = 7;  // almost-full: level >= DEPTH - AF_GAP
  localparam int unsigned SYNC_N  = 2;

  typedef logic [DATA_W-1:0] byte_t;
endpackage

// File: rtl/dcfifo_sync.sv
`timescale 1ns/100ps
module dcfifo_sync #(
  parameter int unsigned W      = 8,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stg[g] <= '0;
        else         stg[g] <= d_i;
      end
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stg[g] <= '0;
        else         stg[g] <= stg[g-1];
      end
    end
  end

  assign q_o = stg[STAGES-1];
endmodule

// File: rtl/dcfifo_ram.sv
`timescale 1ns/100ps
module dcfifo_ram
  import dcfifo_pkg::*;
#(
  parameter int unsigned DEPTH = 256,
  localparam int unsigned AW   = $clog2(DEPTH)
) (
  input  logic          wclk_i,
  input  logic          wen_i,
  input  logic [AW-1:0] waddr_i,
  input  byte_t         wdata_i,
  input  logic          rclk_i,
  input  logic          rst_ni,
  input  logic          ren_i,
  input  logic [AW-1:0] raddr_i,
  output byte_t         rdata_o
);
  byte_t mem [DEPTH];
  byte_t q;

  always_ff @(posedge wclk_i) begin
    if (wen_i) mem[waddr_i] <= wdata_i;
  end

  always_ff @(posedge rclk_i or negedge rst_ni) begin
    if (!rst_ni)    q <= '0;
    else if (ren_i) q <= mem[raddr_i];
  end

  assign rdata_o = q;
endmodule

// File: rtl/dcfifo_wr_side.sv
`timescale 1ns/100ps
module dcfifo_wr_side
  import dcfifo_pkg::*;
#(
  parameter int unsigned DEPTH = 256,
  localparam int unsigned AW   = $clog2(DEPTH),
  localparam int unsigned PW   = AW + 1
) (
  input  logic          wclk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [PW-1:0] rgray_s_i,
  output logic          push_o,
  output logic [PW-1:0] wbin_o,
  output logic [PW-1:0] wgray_o,
  output logic          full_o,
  output logic          afull_o
);
  localparam logic [PW-1:0] FULL_LVL = PW'(DEPTH);
  localparam logic [PW-1:0] AF_LVL   = PW'(DEPTH - AF_GAP);

  logic [PW-1:0] wbin, wbin_nxt, wgray, rbin_s, level;

  always_comb begin
    for (int i = 0; i < PW; i++) rbin_s[i] = ^(rgray_s_i >> i);
  end

  assign level    = wbin - rbin_s;
  assign full_o   = (level == FULL_LVL);
  assign afull_o  = (level >= AF_LVL);
  assign push_o   = we_i & ~full_o;
  assign wbin_nxt = wbin + PW'(push_o);

  always_ff @(posedge wclk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wbin  <= '0;
      wgray <= '0;
    end else begin
      wbin  <= wbin_nxt;
      wgray <= wbin_nxt ^ (wbin_nxt >> 1);
    end
  end

  assign wbin_o  = wbin;
  assign wgray_o = wgray;
endmodule

// File: rtl/dcfifo_rd_side.sv
`timescale 1ns/100ps
module dcfifo_rd_side
  import dcfifo_pkg::*;
#(
  parameter int unsigned DEPTH = 256,
  localparam int unsigned AW   = $clog2(DEPTH),
  localparam int unsigned PW   = AW + 1
) (
  input  logic          rclk_i,
  input  logic          rst_ni,
  input  logic          re_i,
  input  logic [PW-1:0] wgray_s_i,
  output logic          pop_o,
  output logic [PW-1:0] rbin_o,
  output logic [PW-1:0] rgray_o,
  output logic          empty_o,
  output logic          aempty_o
);
  localparam logic [PW-1:0] AE_LVL = PW'(AE_GAP);

  logic [PW-1:0] rbin, rbin_nxt, rgray, wbin_s, level;

  always_comb begin
    for (int i = 0; i < PW; i++) wbin_s[i] = ^(wgray_s_i >> i);
  end

  assign level    = wbin_s - rbin;
  assign empty_o  = (level == '0);
  assign aempty_o = (level <= AE_LVL);
  assign pop_o    = re_i & ~empty_o;
  assign rbin_nxt = rbin + PW'(pop_o);

  always_ff @(posedge rclk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rbin  <= '0;
      rgray <= '0;
    end else begin
      rbin  <= rbin_nxt;
      rgray <= rbin_nxt ^ (rbin_nxt >> 1);
    end
  end

  assign rbin_o  = rbin;
  assign rgray_o = rgray;
endmodule

// File: rtl/dcfifo.sv
`timescale 1ns/100ps
module dcfifo
  import dcfifo_pkg::*;
#(
  parameter int unsigned DEPTH = 256  // power of two, 64..4096
) (
  input  logic        wclk_i,
  input  logic        rclk_i,
  input  logic        rst_ni,
  input  logic        we_i,
  input  logic [7:0]  wdata_i,
  input  logic        re_i,
  input  logic        oe_i,
  output logic [7:0]  rdata_o,
  output logic        empty_o,
  output logic        aempty_o,
  output logic        full_o,
  output logic        afull_o
);
  localparam int unsigned AW = $clog2(DEPTH);
  localparam int unsigned PW = AW + 1;

  logic          push, pop;
  logic [PW-1:0] wptr_bin, wptr_gray, rptr_bin, rptr_gray;
  logic [PW-1:0] wgray_s, rgray_s;
  byte_t         rd_q;

  dcfifo_wr_side #(.DEPTH(DEPTH)) u_wr (
    .wclk_i   (wclk_i),
    .rst_ni   (rst_ni),
    .we_i     (we_i),
    .rgray_s_i(rgray_s),
    .push_o   (push),
    .wbin_o   (wptr_bin),
    .wgray_o  (wptr_gray),
    .full_o   (full_o),
    .afull_o  (afull_o)
  );

  dcfifo_rd_side #(.DEPTH(DEPTH)) u_rd (
    .rclk_i   (rclk_i),
    .rst_ni   (rst_ni),
    .re_i     (re_i),
    .wgray_s_i(wgray_s),
    .pop_o    (pop),
    .rbin_o   (rptr_bin),
    .rgray_o  (rptr_gray),
    .empty_o  (empty_o),
    .aempty_o (aempty_o)
  );

  dcfifo_sync #(.W(PW), .STAGES(SYNC_N)) u_w2r (
    .clk_i (rclk_i),
    .rst_ni(rst_ni),
    .d_i   (wptr_gray),
    .q_o   (wgray_s)
  );

  dcfifo_sync #(.W(PW), .STAGES(SYNC_N)) u_r2w (
    .clk_i (wclk_i),
    .rst_ni(rst_ni),
    .d_i   (rptr_gray),
    .q_o   (rgray_s)
  );

  dcfifo_ram #(.DEPTH(DEPTH)) u_ram (
    .wclk_i (wclk_i),
    .wen_i  (push),
    .waddr_i(wptr_bin[AW-1:0]),
    .wdata_i(wdata_i),
    .rclk_i (rclk_i),
    .rst_ni (rst_ni),
    .ren_i  (pop),
    .raddr_i(rptr_bin[AW-1:0]),
    .rdata_o(rd_q)
  );

  assign rdata_o = oe_i ? rd_q : {DATA_W{1'bz}};
endmodule

// File: rtl/dcfifo_chk.sv
`timescale 1ns/100ps
module dcfifo_chk #(
  parameter int unsigned PW = 9
) (
  input logic          wclk_i,
  input logic          rclk_i,
  input logic          rst_ni,
  input logic          we_i,
  input logic          re_i,
  input logic          full_o,
  input logic          afull_o,
  input logic          empty_o,
  input logic          aempty_o,
  input logic [PW-1:0] wptr_bin,
  input logic [PW-1:0] rptr_bin,
  input logic [PW-1:0] wptr_gray,
  input logic [PW-1:0] rptr_gray,
  input logic [7:0]    rd_q
);
  assert_wr_full_hold_R3: assert property (@(posedge wclk_i) disable iff (!rst_ni)
    (full_o && we_i) |=> $stable(wptr_bin));

  assert_rd_empty_hold_R4: assert property (@(posedge rclk_i) disable iff (!rst_ni)
    (empty_o && re_i) |=> ($stable(rptr_bin) && $stable(rd_q)));

  assert_wptr_step_R1: assert property (@(posedge wclk_i) disable iff (!rst_ni)
    we_i |=> ((wptr_bin == $past(wptr_bin)) || (wptr_bin == PW'($past(wptr_bin) + 1'b1))));

  assert_wgray_one_bit_R7: assert property (@(posedge wclk_i) disable iff (!rst_ni)
    $countones(wptr_gray ^ $past(wptr_gray)) <= 1);

  assert_rgray_one_bit_R7: assert property (@(posedge rclk_i) disable iff (!rst_ni)
    $countones(rptr_gray ^ $past(rptr_gray)) <= 1);

  assert_empty_aempty_R5: assert property (@(posedge rclk_i) disable iff (!rst_ni)
    empty_o |-> aempty_o);

  assert_full_afull_R6: assert property (@(posedge wclk_i) disable iff (!rst_ni)
    full_o |-> afull_o);
endmodule

bind dcfifo dcfifo_chk #(.PW(PW)) u_chk (
  .wclk_i   (wclk_i),
  .rclk_i   (rclk_i),
  .rst_ni   (rst_ni),
  .we_i     (we_i),
  .re_i     (re_i),
  .full_o   (full_o),
  .afull_o  (afull_o),
  .empty_o  (empty_o),
  .aempty_o (aempty_o),
  .wptr_bin (wptr_bin),
  .rptr_bin (rptr_bin),
  .wptr_gray(wptr_gray),
  .rptr_gray(rptr_gray),
  .rd_q     (rd_q)
);

// File: tb/sim_dcfifo.sv
`timescale 1ns/100ps
module sim_dcfifo;
  localparam int DEPTH  = 64;
  localparam int N_ASYN = 300;

  logic       wclk = 1'b0, aclk = 1'b0, tied = 1'b1;
  logic       rst_n = 1'b0, we = 1'b0, re = 1'b0, oe = 1'b1;
  logic [7:0] wd = '0;
  wire        rclk;
  wire  [7:0] rdata;
  wire        empty, aempty, full, afull;

  assign rclk = tied ? wclk : aclk;

  always #2.5 wclk = ~wclk;
  always #3.7 aclk = ~aclk;

  dcfifo #(.DEPTH(DEPTH)) u0 (
    .wclk_i(wclk), .rclk_i(rclk), .rst_ni(rst_n),
    .we_i(we), .wdata_i(wd), .re_i(re), .oe_i(oe),
    .rdata_o(rdata), .empty_o(empty), .aempty_o(aempty),
    .full_o(full), .afull_o(afull)
  );

  int checks = 0, failures = 0;

  // reference model: counts, two-edge delayed views, data queue
  int wcnt, wd1, wview, rcnt, rd1, rview;
  logic [7:0] mq[$];
  logic [7:0] mrd;
  int pushed, popped;

  task automatic chk(input string tag, input string what, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic model_reset();
    wcnt = 0; wd1 = 0; wview = 0; rcnt = 0; rd1 = 0; rview = 0;
    mq.delete(); mrd = 8'h00; pushed = 0; popped = 0;
  endtask

  task automatic check_reset();
    chk("R8", "empty",  {7'b0, empty},  8'h01);
    chk("R8", "aempty", {7'b0, aempty}, 8'h01);
    chk("R8", "full",   {7'b0, full},   8'h00);
    chk("R8", "afull",  {7'b0, afull},  8'h00);
    chk("R8", "rdata",  rdata,          8'h00);
  endtask

  task automatic step(input logic w, input logic [7:0] d, input logic r, input logic o, input string tag);
    int lr, lw;
    logic aw, ar;
    @(negedge wclk);
    we = w; wd = d; re = r; oe = o;
    @(posedge wclk);
    lr = wview - rcnt;
    lw = wcnt - rview;
    aw = w && (lw != DEPTH);
    ar = r && (lr != 0);
    if (aw) mq.push_back(d);
    if (ar) mrd = mq.pop_front();
    wview = wd1; wd1 = wcnt; wcnt = wcnt + int'(aw);
    rview = rd1; rd1 = rcnt; rcnt = rcnt + int'(ar);
    #1;
    chk("R5", "empty",  {7'b0, empty},  {7'b0, (wview - rcnt) == 0});
    chk("R5", "aempty", {7'b0, aempty}, {7'b0, (wview - rcnt) <= 7});
    chk("R6", "full",   {7'b0, full},   {7'b0, (wcnt - rview) == DEPTH});
    chk("R6", "afull",  {7'b0, afull},  {7'b0, (wcnt - rview) >= DEPTH - 7});
    if (o) chk(tag,  "rdata", rdata, mrd);
    else   chk("R9", "rdata", rdata, 8'hzz);
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
  endtask

  initial begin
    repeat (120000) @(posedge wclk);
    checks++;
    failures++;
    $display("FAIL R7 watchdog actual=hung expected=done");
    summary();
    $finish;
  end

  initial begin
    model_reset();
    #12;
    check_reset();
    @(negedge wclk) rst_n = 1'b1;

    // R4: reads on an empty buffer leave output at reset value
    repeat (3) step(1'b0, 8'h00, 1'b1, 1'b1, "R4");

    // R1: store a short burst, let flags settle
    for (int i = 0; i < 10; i++) step(1'b1, 8'hA0 + 8'(i), 1'b0, 1'b1, "R1");
    repeat (3) step(1'b0, 8'h00, 1'b0, 1'b1, "R1");

    // R2 and R9: drain with the output enable toggling
    for (int i = 0; i < 10; i++) step(1'b0, 8'h00, 1'b1, (i % 3) != 1, "R2");
    step(1'b0, 8'h00, 1'b0, 1'b1, "R9");
    repeat (3) step(1'b0, 8'h00, 1'b1, 1'b1, "R4");

    // R3: overfill then drain; dropped bytes must not appear
    for (int i = 0; i < 72; i++) step(1'b1, 8'(i * 7 + 3), 1'b0, 1'b1, "R3");
    repeat (3) step(1'b0, 8'h00, 1'b0, 1'b1, "R3");
    for (int i = 0; i < 70; i++) step(1'b0, 8'h00, 1'b1, 1'b1, "R3");

    // R2: simultaneous streaming
    for (int i = 0; i < 40; i++) step(1'b1, 8'h40 + 8'(i), 1'b1, 1'b1, "R2");
    repeat (12) step(1'b0, 8'h00, 1'b1, 1'b1, "R2");

    // unrelated read clock
    @(negedge wclk);
    rst_n = 1'b0; we = 1'b0; re = 1'b0; oe = 1'b1;
    tied = 1'b0;
    #20;
    model_reset();
    check_reset();
    @(negedge wclk) rst_n = 1'b1;

    fork
      begin : writer
        int n;
        n = 0;
        while (n < N_ASYN) begin
          @(negedge wclk);
          checks++;
          if (!full && (pushed - popped) >= DEPTH) begin
            failures++;
            $display("FAIL R7 full_low_without_space actual=%0d expected<%0d", pushed - popped, DEPTH);
          end
          we = !full && ($urandom_range(3) != 0) && ((n / 80) % 2 == 0 || $urandom_range(1) == 1);
          wd = 8'(n * 5 + 1);
          @(posedge wclk);
          if (we) begin
            mq.push_back(wd);
            pushed++;
            n++;
          end
        end
        @(negedge wclk) we = 1'b0;
      end
      begin : reader
        logic [7:0] exp;
        while (popped < N_ASYN) begin
          @(negedge aclk);
          checks++;
          if (!empty && (pushed - popped) <= 0) begin
            failures++;
            $display("FAIL R7 empty_low_without_data actual=%0d expected>0", pushed - popped);
          end
          re = !empty && ($urandom_range(2) != 0);
          @(posedge aclk);
          if (re) begin
            exp = mq.pop_front();
            popped++;
            #1;
            chk("R7", "async_rdata", rdata, exp);
          end
        end
        @(negedge aclk) re = 1'b0;
      end
    join

    repeat (10) @(negedge aclk);
    chk("R5", "async_final_empty", {7'b0, empty}, 8'h01);
    summary();
    $finish;
  end
endmodule